// File: doc/BRIEF.md
# Timestamped RLE Cluster Packer

This block turns a stream of 16-bit logic samples into a run-length compressed record for an external sample memory. Samples first pass through a format stage. It either keeps each sample as one word or bit-interleaves two 8-channel samples or four 4-channel samples into one word. A new word is written only when it differs from the word before it. Every written word is filed under a 16-bit timestamp. The timestamp counts word periods since reset.

Memory is organised as clusters of eight words. Slot 0 of a cluster holds the timestamp, and slots 1 to 7 hold sample words. The word in slot n belongs to timestamp + n - 1. A run of changes on consecutive ticks fills the open cluster. A change after a gap, a full cluster, or a timestamp wrap to zero starts the next cluster.

Writes leave on two lanes so that one tick can open a cluster and store its first sample together. The timestamp lane and the sample lane each carry an enable, a 24-bit address and 16 bits of data. The address gives the row in bits 23:9, the cluster in bits 8:3 and the slot in bits 2:0, so 64 clusters fill one 512-word row.

Top module: `rle_cluster_packer`

## Requirements
- R1: While reset is high and on the first cycle after it, both write enables are low. The first stored word after reset opens cluster 0 (timestamp address 0x000000) with timestamp 0.
- R2: With `fmt_sel` = 0 (or 3), each valid sample becomes one word, with channel i in bit i.
- R3: With `fmt_sel` = 1, two consecutive valid samples form one word. Bit 2*i+j holds channel i of sample j (j = 0 first). Channels 8 to 15 are ignored.
- R4: With `fmt_sel` = 2, four consecutive valid samples form one word. Bit 4*i+j holds channel i of sample j. Channels 4 to 15 are ignored.
- R5: The timestamp advances by one per completed word. Cycles with `smp_valid` low neither advance it nor store anything.
- R6: A completed word equal to the previous completed word is not written, except under R10.
- R7: A changed word whose timestamp is exactly one past the last stored word goes to the next slot of the open cluster. Only the sample lane writes.
- R8: Any other stored word opens the next cluster in the same cycle. The timestamp lane writes the timestamp to slot 0, and the sample lane writes the word to slot 1.
- R9: A cluster whose seven sample slots are filled takes no more words. The next stored word opens a new cluster.
- R10: A word completed at timestamp 0 (after a 65536-tick wrap) is always stored and always opens a new cluster, even when unchanged.
- R11: Addresses are {row[14:0], cluster[5:0], slot[2:0]}. The cluster index runs on across row boundaries, so cluster 64 is address 0x000200.
- R12: Writes appear on the outputs two clock edges after the edge that samples the input completing the word.
- R13: `fmt_sel` is captured only while reset is high. Changes afterwards have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `fmt_sel` |
| fmt_sel | input | 2 | Word format: 0/3 one sample, 1 two samples, 2 four samples |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Channel levels |
| ts_we | output | 1 | Timestamp lane write enable |
| ts_addr | output | 24 | Timestamp lane word address |
| ts_data | output | 16 | Timestamp value |
| smp_we | output | 1 | Sample lane write enable |
| smp_addr | output | 24 | Sample lane word address |
| smp_wdata | output | 16 | Packed sample word |

## Verification
Every write is due two edges after the edge that samples the input completing its word: one edge for the format register and one for the output registers. Timestamp and sample lanes are due in the same cycle. The bench drives inputs on falling edges and runs a behavioural model for each driven cycle. It delays the model's result through a two-deep line and compares it against the outputs at the second falling edge. This puts every comparison half a cycle away from any active edge. Enables are compared every cycle, and addresses and data whenever a write is expected. A reset empties the delay line so that its own two-cycle effect is checked the same way.

// File: rtl/rle_pack_pkg.sv
package rle_pack_pkg;

  typedef enum logic [1:0] {
    FMT_SINGLE = 2'd0,
    FMT_PAIR   = 2'd1,
    FMT_QUAD   = 2'd2,
    FMT_ALT    = 2'd3
  } fmt_e;

  // log2 of the samples folded into one word
  function automatic logic [1:0] fmt_shift(input fmt_e f);
    case (f)
      FMT_PAIR: return 2'd1;
      FMT_QUAD: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/rcp_interleave.sv
module rcp_interleave
  import rle_pack_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              word_valid,
  output logic [DATA_W-1:0] word
);
  localparam int CH_W = $clog2(DATA_W);

  logic [1:0]        sh;
  logic [1:0]        sub_mask;
  logic [1:0]        sub_idx;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] nxt;

  assign sh       = fmt_shift(fmt);
  assign sub_mask = 2'((3'd1 << sh) - 3'd1);

  // output bit b carries channel b>>sh of sub-sample b & mask
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic [1:0]      bsub;
    logic [CH_W-1:0] ch;
    assign bsub = 2'(b) & sub_mask;
    assign ch   = CH_W'(b >> sh);
    assign nxt[b] = (bsub == sub_idx) ? in_sample[ch] : acc[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_idx    <= '0;
      acc        <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (in_valid) begin
        acc <= nxt;
        if (sub_idx == sub_mask) begin
          sub_idx    <= '0;
          word_valid <= 1'b1;
          word       <= nxt;
        end else begin
          sub_idx <= sub_idx + 2'd1;
        end
      end
    end
  end

  // R12: a word only follows a sampled input
  a_r12_word_follows_input: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(in_valid));

  // R4: sub-sample position never passes the group size
  a_r4_sub_in_range: assert property (@(posedge clk) disable iff (rst)
    sub_idx <= sub_mask);

endmodule

// File: rtl/rcp_change_detect.sv
module rcp_change_detect #(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word,
  output logic              store,
  output logic              force_new,
  output logic [TS_W-1:0]   ts
);
  logic [TS_W-1:0]   ts_cnt;
  logic [DATA_W-1:0] prev;
  logic              seen;

  assign ts        = ts_cnt;
  assign force_new = (ts_cnt == '0);
  assign store     = word_valid && (!seen || (word != prev) || force_new);

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_cnt <= '0;
      prev   <= '0;
      seen   <= 1'b0;
    end else if (word_valid) begin
      ts_cnt <= ts_cnt + 1'b1;
      prev   <= word;
      seen   <= 1'b1;
    end
  end

  // R5: one tick per completed word
  a_r5_tick_per_word: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> ts_cnt == $past(ts_cnt) + 1'b1);

  // R5: no tick without a word
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> $stable(ts_cnt));

endmodule

// File: rtl/rcp_cluster_writer.sv
module rcp_cluster_writer #(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int ROW_W  = 15,
  parameter int CL_W   = 6,
  parameter int SLOT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          store,
  input  logic                          force_new,
  input  logic [TS_W-1:0]               ts,
  input  logic [DATA_W-1:0]             word,
  output logic                          ts_we,
  output logic [ROW_W+CL_W+SLOT_W-1:0]  ts_addr,
  output logic [DATA_W-1:0]             ts_data,
  output logic                          s_we,
  output logic [ROW_W+CL_W+SLOT_W-1:0]  s_addr,
  output logic [DATA_W-1:0]             s_data
);
  localparam int IDX_W = ROW_W + CL_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};

  logic              open_q;
  logic [SLOT_W-1:0] fill;
  logic [IDX_W-1:0]  cl;
  logic [TS_W-1:0]   last_ts;
  logic              append;
  logic [IDX_W-1:0]  next_cl;

  assign append  = open_q && !force_new && (ts == last_ts + 1'b1) && (fill != LAST_SLOT);
  assign next_cl = open_q ? cl + 1'b1 : cl;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      fill    <= '0;
      cl      <= '0;
      last_ts <= '0;
      ts_we   <= 1'b0;
      ts_addr <= '0;
      ts_data <= '0;
      s_we    <= 1'b0;
      s_addr  <= '0;
      s_data  <= '0;
    end else begin
      ts_we <= 1'b0;
      s_we  <= 1'b0;
      if (store) begin
        last_ts <= ts;
        s_we    <= 1'b1;
        s_data  <= word;
        if (append) begin
          fill   <= fill + 1'b1;
          s_addr <= {cl, fill + 1'b1};
        end else begin
          cl      <= next_cl;
          open_q  <= 1'b1;
          fill    <= SLOT_W'(1);
          ts_we   <= 1'b1;
          ts_addr <= {next_cl, {SLOT_W{1'b0}}};
          ts_data <= DATA_W'(ts);
          s_addr  <= {next_cl, SLOT_W'(1)};
        end
      end
    end
  end

  // R8: a cluster header always comes with its first sample in slot 1
  a_r8_header_pairs_sample: assert property (@(posedge clk) disable iff (rst)
    ts_we |-> (s_we && s_addr == ts_addr + 1'b1));

  // R11: timestamps in slot 0, samples never there
  a_r11_header_slot: assert property (@(posedge clk) disable iff (rst)
    ts_we |-> ts_addr[SLOT_W-1:0] == '0);
  a_r11_sample_slot: assert property (@(posedge clk) disable iff (rst)
    s_we |-> s_addr[SLOT_W-1:0] != '0);

  // R7: an appended word lands right after the previous sample address
  a_r7_append_next_slot: assert property (@(posedge clk) disable iff (rst)
    (s_we && !ts_we) |-> s_addr == $past(s_addr) + 1'b1);

  // R10: a word at timestamp zero opens a cluster
  a_r10_wrap_opens: assert property (@(posedge clk) disable iff (rst)
    (store && force_new) |=> ts_we);

endmodule

// File: rtl/rle_cluster_packer.sv
module rle_cluster_packer
  import rle_pack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TS_W   = 16,
  parameter int ROW_W  = 15,
  parameter int CL_W   = 6,
  parameter int SLOT_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   fmt_sel,
  input  logic                         smp_valid,
  input  logic [DATA_W-1:0]            smp_data,
  output logic                         ts_we,
  output logic [ROW_W+CL_W+SLOT_W-1:0] ts_addr,
  output logic [DATA_W-1:0]            ts_data,
  output logic                         smp_we,
  output logic [ROW_W+CL_W+SLOT_W-1:0] smp_addr,
  output logic [DATA_W-1:0]            smp_wdata
);
  fmt_e              fmt_q;
  logic              w_valid;
  logic [DATA_W-1:0] w_data;
  logic              st;
  logic              fnew;
  logic [TS_W-1:0]   ts_cur;

  always_ff @(posedge clk) begin
    if (rst) fmt_q <= fmt_e'(fmt_sel);
  end

  rcp_interleave #(.DATA_W(DATA_W)) u_ilv (
    .clk(clk), .rst(rst), .fmt(fmt_q),
    .in_valid(smp_valid), .in_sample(smp_data),
    .word_valid(w_valid), .word(w_data)
  );

  rcp_change_detect #(.DATA_W(DATA_W), .TS_W(TS_W)) u_chg (
    .clk(clk), .rst(rst), .word_valid(w_valid), .word(w_data),
    .store(st), .force_new(fnew), .ts(ts_cur)
  );

  rcp_cluster_writer #(.DATA_W(DATA_W), .TS_W(TS_W), .ROW_W(ROW_W),
                       .CL_W(CL_W), .SLOT_W(SLOT_W)) u_wr (
    .clk(clk), .rst(rst), .store(st), .force_new(fnew), .ts(ts_cur), .word(w_data),
    .ts_we(ts_we), .ts_addr(ts_addr), .ts_data(ts_data),
    .s_we(smp_we), .s_addr(smp_addr), .s_data(smp_wdata)
  );

  // R1: lanes idle on the cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!ts_we && !smp_we));

  // R13: format register only moves under reset
  a_r13_fmt_locked: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(fmt_q));

endmodule

// File: tb/rle_cluster_packer_bench.sv
module rle_cluster_packer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'd0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        ts_we, smp_we;
  logic [23:0] ts_addr, smp_addr;
  logic [15:0] ts_data, smp_wdata;

  always #2 clk = ~clk;

  rle_cluster_packer u_rle_cluster_packer (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .smp_valid(smp_valid), .smp_data(smp_data),
    .ts_we(ts_we), .ts_addr(ts_addr), .ts_data(ts_data),
    .smp_we(smp_we), .smp_addr(smp_addr), .smp_wdata(smp_wdata)
  );

  typedef struct packed {
    logic tw; logic [23:0] ta; logic [15:0] td;
    logic sw; logic [23:0] sa; logic [15:0] sd;
  } exp_t;

  int checks = 0;
  int errors = 0;
  string req = "R1";
  exp_t d1 = '0, d2 = '0;

  // reference model state
  int m_k = 1, m_sub = 0, m_ts = 0, m_last = 0, m_fill = 0, m_cl = 0;
  bit m_seen = 0, m_open = 0;
  logic [15:0] m_acc = '0, m_prev = '0;

  function automatic exp_t model(input bit v, input logic [15:0] s);
    exp_t e = '0;
    logic [15:0] w;
    int t;
    if (!v) return e;
    for (int b = 0; b < 16; b++)
      if ((b % m_k) == m_sub) m_acc[b] = s[b / m_k];
    if (m_sub != m_k - 1) begin
      m_sub++;
      return e;
    end
    m_sub = 0;
    w = m_acc;
    t = m_ts;
    m_ts = (m_ts + 1) % 65536;
    if (!m_seen || w != m_prev || t == 0) begin
      e.sw = 1'b1;
      e.sd = w;
      if (m_open && t != 0 && t == (m_last + 1) % 65536 && m_fill < 7) begin
        m_fill++;
        e.sa = 24'(m_cl * 8 + m_fill);
      end else begin
        if (m_open) m_cl = (m_cl + 1) % (1 << 21);
        m_open = 1;
        m_fill = 1;
        e.tw = 1'b1;
        e.ta = 24'(m_cl * 8);
        e.td = 16'(t);
        e.sa = 24'(m_cl * 8 + 1);
      end
      m_last = t;
    end
    m_seen = 1;
    m_prev = w;
    return e;
  endfunction

  task automatic compare();
    bit bad = 0;
    checks++;
    if (ts_we !== d2.tw || (d2.tw && (ts_addr !== d2.ta || ts_data !== d2.td))) begin
      bad = 1;
      $display("FAIL %s ts lane: got we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
               req, ts_we, ts_addr, ts_data, d2.tw, d2.ta, d2.td);
    end
    if (smp_we !== d2.sw || (d2.sw && (smp_addr !== d2.sa || smp_wdata !== d2.sd))) begin
      bad = 1;
      $display("FAIL %s sample lane: got we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
               req, smp_we, smp_addr, smp_wdata, d2.sw, d2.sa, d2.sd);
    end
    if (bad) errors++;
  endtask

  task automatic step(input bit v, input logic [15:0] s);
    @(negedge clk);
    compare();
    d2 = d1;
    rst = 1'b0;
    smp_valid = v;
    smp_data = s;
    d1 = model(v, s);
  endtask

  task automatic do_reset(input logic [1:0] f);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare();
      rst = 1'b1;
      fmt_sel = f;
      smp_valid = 1'b0;
      d1 = '0;
      d2 = '0;
    end
    m_k = (f == 2'd1) ? 2 : (f == 2'd2) ? 4 : 1;
    m_sub = 0; m_ts = 0; m_last = 0; m_fill = 0; m_cl = 0;
    m_seen = 0; m_open = 0; m_acc = '0; m_prev = '0;
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog expired");
    errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state and first cluster at address 0
    req = "R1";
    do_reset(2'd0);
    @(negedge clk);
    checks++;
    if (ts_we !== 1'b0 || smp_we !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle after reset: got ts_we=%0b smp_we=%0b expected 0 0", ts_we, smp_we);
    end
    step(1, 16'h0001);
    // R2 R7 R9: twenty consecutive changes fill and overflow clusters
    req = "R2 R7 R9";
    for (int i = 0; i < 20; i++) step(1, 16'(i * 16'h1357 + 3));
    // R6 R8: unchanged words skipped, later change opens a cluster
    req = "R6 R8";
    for (int i = 0; i < 5; i++) step(1, 16'hBEEF);
    step(1, 16'h4242);
    step(1, 16'h4242);
    step(1, 16'h0F0F);
    // R5: invalid cycles carry no tick and are ignored
    req = "R5";
    for (int i = 0; i < 4; i++) step(0, 16'(i * 16'h1111));
    step(1, 16'h0F0E);
    step(0, 16'hFFFF);
    step(1, 16'h0F0D);
    // R11: gapped changes walk across a row boundary
    req = "R11";
    for (int i = 0; i < 150; i++) step(1, (i % 2 == 0) ? 16'(i) : 16'(i - 1));
    // R12: single isolated change, latency through the pipeline
    req = "R12";
    step(1, 16'hA5A5);
    for (int i = 0; i < 3; i++) step(0, 16'h0);
    // R10: constant input across a timestamp wrap
    req = "R10";
    do_reset(2'd0);
    for (int i = 0; i < 65540; i++) step(1, 16'h1234);
    // R3: two-sample words, upper channels ignored
    req = "R3";
    do_reset(2'd1);
    for (int i = 0; i < 24; i++) step(1, 16'(i * 16'h0123));
    for (int i = 0; i < 8; i++) step(1, 16'(16'h5500 | ((i & 1) ? 16'hFF00 : 16'h0000)));
    // R4: four-sample words, upper channels ignored
    req = "R4";
    do_reset(2'd2);
    for (int i = 0; i < 40; i++) step(1, 16'(i * 16'h0765));
    for (int i = 0; i < 16; i++) step(1, 16'(16'h0009 | (16'(i) << 4)));
    // R13: format change without reset has no effect
    req = "R13";
    fmt_sel = 2'd0;
    for (int i = 0; i < 16; i++) step(1, 16'(i * 16'h0321));
    // R2: code 3 behaves as single-sample format
    req = "R2";
    do_reset(2'd3);
    for (int i = 0; i < 12; i++) step(1, 16'((i / 2) * 16'h1001));
    step(0, 16'h0);
    step(0, 16'h0);
    step(0, 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule